// File: doc/BRIEF.md
# String Move Address Sequencer

This block runs a repeated block copy the way a segmented processor repeats a string move. A start pulse loads three working registers: a source offset, a destination offset and an element count. It also captures the two segment values, the element size and the step direction. For each element the block first reads from the source location, then writes the captured data to the destination location. After the write is acknowledged it moves both offsets by one element and lowers the count by one. It stops when the count reaches zero.

A physical address is formed from a 16-bit segment and a 16-bit offset. The segment is shifted left by four bits, the offset is added, and the sum is cut to 20 bits. Source accesses use the data segment input. Destination accesses always use the extra segment input. The memory side is a single request/acknowledge port with a write flag and byte lanes.

The sequencer has four states:
- `ST_IDLE` waits for start.
- `ST_READ` holds the source read request.
- `ST_WRITE` holds the destination write request.
- `ST_FINISH` raises done for one cycle.

The transitions are:
- IDLE→READ: start with a nonzero count.
- IDLE→FINISH: start with a zero count.
- READ→WRITE: read acknowledge.
- WRITE→READ: write acknowledge with more than one element left.
- WRITE→FINISH: write acknowledge on the last element.
- FINISH→IDLE: unconditional.

Top module: `strmov_seq`

## Requirements
- R1: A start pulse seen in idle copies `src_init`, `dst_init` and `cnt_init` into `src_idx`, `dst_idx` and `cnt` at that clock edge, and `busy` is high from the next cycle until the sequence returns to idle.
- R2: If `cnt_init` is zero at start, no memory request is made and `done` is high in the cycle right after the start edge.
- R3: Each element read has `mem_we` = 0 and `mem_addr` = ((`ds_seg` << 4) + `src_idx`) mod 2^20.
- R4: Each element write has `mem_we` = 1 and `mem_addr` = ((`es_seg` << 4) + `dst_idx`) mod 2^20. Its `mem_wdata` is the read data of that element with the lanes that `mem_be` disables forced to zero.
- R5: The read of an element is acknowledged before its write is requested. A request keeps its address and write flag unchanged until it is acknowledged.
- R6: After each write acknowledge, both offsets move by the element size in bytes: 1, 2 or 4. They increase when `dir_down` was 0 at start and decrease when it was 1, wrapping modulo 2^16.
- R7: `cnt` drops by one after each write acknowledge. Exactly `cnt_init` element pairs are issued. `done` is a single-cycle pulse that follows the last write acknowledge.
- R8: `elem_size` codes are 0 for byte, 1 for word, 2 for doubleword, and 3 is treated as doubleword. `mem_be` is 4'b0001, 4'b0011 or 4'b1111 respectively, and data sits in the low lanes.
- R9: A start pulse while `busy` is high is ignored. The running copy ends with the same results as without it.
- R10: After `done`, `src_idx`, `dst_idx` and `cnt` keep their final values and no request is made until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy (taken only when idle) |
| dir_down | input | 1 | 0: offsets increase, 1: offsets decrease |
| elem_size | input | 2 | Element size code |
| ds_seg | input | 16 | Source segment |
| es_seg | input | 16 | Destination segment |
| src_init | input | 16 | Initial source offset |
| dst_init | input | 16 | Initial destination offset |
| cnt_init | input | 16 | Number of elements |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Request accepted this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| src_idx | output | 16 | Current source offset |
| dst_idx | output | 16 | Current destination offset |
| cnt | output | 16 | Remaining element count |

## Verification
The bench targets several corner cases, and each has a visible failure mode:
- **Zero count.** A design that enters the read state anyway issues a stray read.
- **Offset wrap.** The bench uses an offset that wraps past 0xFFFF and a segment whose physical sum overflows 20 bits. A design with a wide adder or a missing truncation emits addresses above the 1 MB space or steps into the wrong page.
- **Decrementing direction and every size code, including the reserved one.** A wrong stride, lane mask or sign shows up as a scoreboard mismatch on address or byte lanes.
- **Start repeated mid-run, and the final register values after done.** These catch a design that reloads while busy or keeps stepping after the last element.

// File: rtl/strmov_pkg.sv
package strmov_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } elem_size_t;
endpackage

// File: rtl/strmov_phys_addr.sv
module strmov_phys_addr #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFS_W-1:0] ofs,
    output logic [PA_W-1:0]  phys
);
    localparam int SUM_W = SEG_W + SHIFT + 1;

    logic [SUM_W-1:0] sum;

    // shifted segment plus zero-extended offset, then cut to the address width
    assign sum  = {1'b0, seg, {SHIFT{1'b0}}} + SUM_W'(ofs);
    assign phys = sum[PA_W-1:0];
endmodule

// File: rtl/strmov_idx_step.sv
module strmov_idx_step #(
    parameter int IDX_W = 16,
    parameter int STR_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             down,
    input  logic [STR_W-1:0] stride,
    output logic [IDX_W-1:0] nxt
);
    always_comb begin
        if (down) nxt = idx - IDX_W'(stride);
        else      nxt = idx + IDX_W'(stride);
    end
endmodule

// File: rtl/strmov_seq.sv
module strmov_seq #(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int CNT_W  = 16,
    parameter int SHIFT  = 4,
    parameter int PA_W   = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_down,
    input  logic [1:0]        elem_size,
    input  logic [SEG_W-1:0]  ds_seg,
    input  logic [SEG_W-1:0]  es_seg,
    input  logic [OFS_W-1:0]  src_init,
    input  logic [OFS_W-1:0]  dst_init,
    input  logic [CNT_W-1:0]  cnt_init,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic [OFS_W-1:0]  src_idx,
    output logic [OFS_W-1:0]  dst_idx,
    output logic [CNT_W-1:0]  cnt
);
    import strmov_pkg::*;

    localparam int BE_W  = DATA_W / 8;
    localparam int STR_W = 3;

    seq_state_t       state_q, state_d;
    logic [OFS_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [SEG_W-1:0] ds_q, es_q;
    logic             down_q;
    logic [STR_W-1:0] stride_q, stride_in;
    logic [DATA_W-1:0] rd_q;
    logic [PA_W-1:0]  src_pa, dst_pa;
    logic [BE_W-1:0]  be_mask;
    logic             take_start;

    assign take_start = (state_q == ST_IDLE) && start;

    // element size code to stride in bytes; reserved code acts as doubleword
    always_comb begin
        unique case (elem_size_t'(elem_size))
            SZ_BYTE:  stride_in = 3'd1;
            SZ_WORD:  stride_in = 3'd2;
            SZ_DWORD: stride_in = 3'd4;
            SZ_RSVD:  stride_in = 3'd4;
        endcase
    end

    always_comb begin
        for (int i = 0; i < BE_W; i++) be_mask[i] = (i < int'(stride_q));
    end

    strmov_phys_addr #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .PA_W(PA_W))
        u_src_pa (.seg(ds_q), .ofs(src_q), .phys(src_pa));
    strmov_phys_addr #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .PA_W(PA_W))
        u_dst_pa (.seg(es_q), .ofs(dst_q), .phys(dst_pa));

    strmov_idx_step #(.IDX_W(OFS_W), .STR_W(STR_W))
        u_src_step (.idx(src_q), .down(down_q), .stride(stride_q), .nxt(src_nxt));
    strmov_idx_step #(.IDX_W(OFS_W), .STR_W(STR_W))
        u_dst_step (.idx(dst_q), .down(down_q), .stride(stride_q), .nxt(dst_nxt));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (cnt_init == '0) ? ST_FINISH : ST_READ;
            end
            ST_READ: begin
                if (mem_ack) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ack) state_d = (cnt_q == CNT_W'(1)) ? ST_FINISH : ST_READ;
            end
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            ds_q     <= '0;
            es_q     <= '0;
            down_q   <= 1'b0;
            stride_q <= 3'd1;
            rd_q     <= '0;
        end else if (take_start) begin
            src_q    <= src_init;
            dst_q    <= dst_init;
            cnt_q    <= cnt_init;
            ds_q     <= ds_seg;
            es_q     <= es_seg;
            down_q   <= dir_down;
            stride_q <= stride_in;
        end else if (state_q == ST_READ && mem_ack) begin
            rd_q <= mem_rdata;
        end else if (state_q == ST_WRITE && mem_ack) begin
            src_q <= src_nxt;
            dst_q <= dst_nxt;
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // write data: enabled lanes pass, the rest are zero
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign mem_wdata[g*8 +: 8] = be_mask[g] ? rd_q[g*8 +: 8] : 8'h00;
    end

    // outputs from state
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = src_pa;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_READ:   mem_req = 1'b1;
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_pa;
            end
            ST_FINISH: done = 1'b1;
        endcase
    end

    assign mem_be  = be_mask;
    assign busy    = (state_q != ST_IDLE);
    assign src_idx = src_q;
    assign dst_idx = dst_q;
    assign cnt     = cnt_q;
endmodule

// File: rtl/strmov_seq_chk.sv
module strmov_seq_chk #(
    parameter int CNT_W = 16,
    parameter int OFS_W = 16,
    parameter int PA_W  = 20,
    parameter int BE_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] cnt_init,
    input logic             mem_req,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic [BE_W-1:0]  mem_be,
    input logic             mem_ack,
    input logic             busy,
    input logic             done,
    input logic [OFS_W-1:0] src_idx,
    input logic [OFS_W-1:0] dst_idx,
    input logic [CNT_W-1:0] cnt
);
    assert_zero_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cnt_init == '0) |=> (done && !mem_req));

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_read_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !$past(mem_we)) |-> $past(mem_req && mem_ack));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (cnt == $past(cnt) - CNT_W'(1)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_lane_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be == BE_W'(1) || mem_be == BE_W'(3) || mem_be == BE_W'(15)));

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(mem_req && mem_we && mem_ack)) |=> ($stable(cnt) && $stable(src_idx)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(cnt) && $stable(src_idx) && $stable(dst_idx) && !mem_req));
endmodule

bind strmov_seq strmov_seq_chk #(.CNT_W(CNT_W), .OFS_W(OFS_W), .PA_W(PA_W), .BE_W(DATA_W/8)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_init(cnt_init),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_ack(mem_ack), .busy(busy), .done(done), .src_idx(src_idx),
    .dst_idx(dst_idx), .cnt(cnt)
);

// File: tb/strmov_seq_tb_top.sv
`timescale 1ns/1ps
module strmov_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_down = 1'b0;
    logic [1:0]  elem_size = 2'd0;
    logic [15:0] ds_seg = '0, es_seg = '0, src_init = '0, dst_init = '0, cnt_init = '0;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        busy, done;
    logic [15:0] src_idx, dst_idx, cnt;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic        we;
        logic [19:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
    } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    strmov_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_down(dir_down),
        .elem_size(elem_size), .ds_seg(ds_seg), .es_seg(es_seg),
        .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .src_idx(src_idx), .dst_idx(dst_idx), .cnt(cnt)
    );

    function automatic logic [19:0] pa(input logic [15:0] seg, input logic [15:0] ofs);
        return {seg, 4'h0} + {4'h0, ofs};
    endfunction

    function automatic logic [31:0] rd_val(input logic [19:0] a);
        return {12'h9E3, a};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: compare one accepted request against the scoreboard head
    task automatic monitor_item();
        item_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R7", "request beyond element count", {12'h0, mem_addr}, 32'h0);
            return;
        end
        e = exp_q.pop_front();
        check(mem_we == e.we, "R5", "read/write order", {31'h0, mem_we}, {31'h0, e.we});
        check(mem_addr == e.addr, e.we ? "R4" : "R3", "address", {12'h0, mem_addr}, {12'h0, e.addr});
        check(mem_be == e.be, "R8", "byte enables", {28'h0, mem_be}, {28'h0, e.be});
        if (e.we)
            check(mem_wdata == e.wdata, "R4", "write data", mem_wdata, e.wdata);
    endtask

    // memory responder with rotating latency 0..2
    initial begin : responder
        int waitc = 0;
        int lat = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (waitc < lat) waitc++;
                else begin
                    monitor_item();
                    mem_rdata = mem_we ? 32'h0 : rd_val(mem_addr);
                    mem_ack   = 1'b1;
                    waitc     = 0;
                    lat       = (lat + 1) % 3;
                end
            end
        end
    end

    // driver: push expected traffic, start the copy, check final state
    task automatic run_copy(input logic [15:0] ds, input logic [15:0] es,
                            input logic [15:0] s0, input logic [15:0] d0,
                            input logic [15:0] n, input logic [1:0] sz,
                            input logic dn, input bit inject);
        logic [15:0] s = s0;
        logic [15:0] d = d0;
        int stride = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        logic [3:0] be = (stride == 1) ? 4'b0001 : (stride == 2) ? 4'b0011 : 4'b1111;
        logic [31:0] mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        int cyc = 0;
        logic [15:0] hs, hd, hc;
        for (int k = 0; k < int'(n); k++) begin
            item_t r, w;
            r.we = 1'b0; r.addr = pa(ds, s); r.be = be; r.wdata = '0;
            w.we = 1'b1; w.addr = pa(es, d); w.be = be; w.wdata = rd_val(r.addr) & mask;
            exp_q.push_back(r);
            exp_q.push_back(w);
            s = dn ? s - 16'(stride) : s + 16'(stride);
            d = dn ? d - 16'(stride) : d + 16'(stride);
        end
        @(negedge clk);
        ds_seg = ds; es_seg = es; src_init = s0; dst_init = d0;
        cnt_init = n; elem_size = sz; dir_down = dn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R1", "busy after start", {31'h0, busy}, 32'h1);
        if (n == 0) begin
            check(done == 1'b1, "R2", "done after zero-count start", {31'h0, done}, 32'h1);
            check(mem_req == 1'b0, "R2", "no request on zero count", {31'h0, mem_req}, 32'h0);
        end else begin
            check(src_idx == s0 && dst_idx == d0 && cnt == n, "R1", "loaded registers",
                  {src_idx, cnt}, {s0, n});
        end
        while (!done && cyc < 5000) begin
            if (inject && cyc == 4) begin
                start = 1'b1; cnt_init = 16'd7; src_init = 16'h5555; dst_init = 16'h6666;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        check(done == 1'b1, "R7", "done reached", {31'h0, done}, 32'h1);
        check(exp_q.size() == 0, inject ? "R9" : "R7", "all elements transferred",
              exp_q.size(), 32'h0);
        check(src_idx == s, "R6", "final source offset", {16'h0, src_idx}, {16'h0, s});
        check(dst_idx == d, "R6", "final destination offset", {16'h0, dst_idx}, {16'h0, d});
        check(cnt == 16'h0, "R7", "final count", {16'h0, cnt}, 32'h0);
        hs = src_idx; hd = dst_idx; hc = cnt;
        @(negedge clk);
        check(done == 1'b0, "R7", "done single cycle", {31'h0, done}, 32'h0);
        repeat (3) @(negedge clk);
        check(src_idx == hs && dst_idx == hd && cnt == hc && !mem_req && !busy, "R10",
              "values held after done", {src_idx, dst_idx}, {hs, hd});
        exp_q.delete();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req && cnt == 16'h0, "R1", "reset state",
              {29'h0, busy, done, mem_req}, 32'h0);
        rst_n = 1'b1;
        // byte, upward
        run_copy(16'h1000, 16'h2000, 16'h0010, 16'h0040, 16'd3, 2'd0, 1'b0, 1'b0);
        // word, downward
        run_copy(16'h0300, 16'h0700, 16'h0080, 16'h0100, 16'd4, 2'd1, 1'b1, 1'b0);
        // doubleword, upward
        run_copy(16'h4000, 16'h4001, 16'h0000, 16'h0008, 16'd3, 2'd2, 1'b0, 1'b0);
        // zero count
        run_copy(16'h1111, 16'h2222, 16'h0033, 16'h0044, 16'd0, 2'd1, 1'b0, 1'b0);
        // offset wrap and 20-bit physical overflow, word upward
        run_copy(16'hFFFF, 16'hF000, 16'hFFFE, 16'hFFFC, 16'd3, 2'd1, 1'b0, 1'b0);
        // doubleword downward through zero
        run_copy(16'h0123, 16'hFFFF, 16'h0002, 16'h0030, 16'd3, 2'd2, 1'b1, 1'b0);
        // start repeated while busy
        run_copy(16'h0500, 16'h0600, 16'h0020, 16'h0090, 16'd4, 2'd0, 1'b0, 1'b1);
        // reserved size code behaves as doubleword
        run_copy(16'h0800, 16'h0900, 16'h0100, 16'h0200, 16'd2, 2'd3, 1'b1, 1'b0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule